// File: doc/BRIEF.md
# Processor-Hot Alert Pulse Controller

This block drives an active-low alert line toward a processor when the power path sees stress. Seven event inputs (comparator output, critical current, nominal current, discharge current, system voltage, battery removal, adapter removal), plus a voltage-regulation event and an exit-from-load-mode event, each set a sticky status bit and start a low pulse on the alert line. A host reads and writes one 16-bit status word through a small register port.

The pulse either lasts a programmed minimum time, counted in 1 µs ticks from a prescaler, or, in extension mode, stays low until the host writes the clear bit. Some status bits clear when the host reads the word. Others hold the alert line low until the host writes them to zero. A counter watches consecutive failed load attempts. After seven in a row it latches a failure flag that keeps the load function off until the host clears it.

Top module: `hot_alert_top`

## Requirements
- R1: After reset the status word reads B800h, `alertN` is 1 and `latchedOff` is 0.
- R2: Events are latched into status bits 6..0: `evtIn[i]` sets bit i. A read at `STAT_ADDR` shows the word combinationally on `rdData`. The clock edge that takes `rdEn` clears bits 6..0 and bit 10. Bit 15 always reads 1.
- R3: If an event and a read-clear fall in the same cycle, the event wins and its bit stays set.
- R4: Bits 13:12 select the minimum pulse width: 00 gives `W_US0`, 01 gives `W_US1`, 10 gives `W_US2` and 11 gives `W_US3` µs. With extension off, `alertN` goes low at the edge that samples an event and stays low for exactly width × `CLK_PER_US` cycles.
- R5: An event during an active pulse restarts the full minimum width from that edge.
- R6: With bit 14 set, a pulse stays low until a write to the status word carries bit 11 = 0. `alertN` rises at that write's edge. Bit 11 always reads 1.
- R7: `vinRegIn` sets bit 7. While bit 7 is set and `vinHoldEn` is 1, `alertN` stays low. Writing 0 to bit 7 clears it, and writing 1 has no effect.
- R8: `exitLoadIn` sets bit 8, which holds `alertN` low until a write of 0 to bit 8.
- R9: Seven consecutive `loadTry` cycles with `loadOk` = 0 set bit 9 and `latchedOff`. A successful try resets the count. Writing 0 to bit 9 releases the latch.
- R10: `tshutIn` sets bit 10 without starting a pulse. The bit clears on read.
- R11: A write to any address other than `STAT_ADDR` leaves the status word unchanged. A read elsewhere returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (clears read-clear bits at the edge) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational |
| evtIn | input | 7 | Trigger events for status bits 6..0 |
| tshutIn | input | 1 | Thermal-shutdown event |
| vinRegIn | input | 1 | Input-voltage-regulation event |
| vinHoldEn | input | 1 | Lets bit 7 hold the alert low |
| exitLoadIn | input | 1 | Exit-from-load-mode event |
| loadTry | input | 1 | One load attempt this cycle |
| loadOk | input | 1 | Result of the attempt (1 = success) |
| alertN | output | 1 | Active-low alert line |
| latchedOff | output | 1 | Load function latched off after repeated failures |

## Verification
The assertions check on every cycle that an event sets its status bit and starts a pulse, and that an extended pulse holds until the clear strobe. They also check that the exit and regulation holds keep the line low, that the failure latch holds until cleared, and that the failure counter never passes its limit. Only the bench scenarios can show the exact pulse length for each width code, the restart on a re-trigger, and the collision between a read-clear and an event. The same goes for the seven-in-a-row count with a success in between, and for writes and reads at a foreign address being ignored.

// File: rtl/hot_alert_pkg.sv
package hot_alert_pkg;
  localparam int EVT_N = 7;
  localparam int WORD_W = 16;

  // Field positions inside the status word.
  localparam int B_RSVD = 15;
  localparam int B_EXT = 14;
  localparam int B_WHI = 13;
  localparam int B_WLO = 12;
  localparam int B_CLR = 11;
  localparam int B_TSHUT = 10;
  localparam int B_FAIL = 9;
  localparam int B_EXIT = 8;
  localparam int B_VIN = 7;

  // Strobes from the register decode to the status datapath and timer.
  typedef struct packed {
    logic rdClr;     // read of the status word: clear read-clear bits
    logic cfgWr;     // load extension enable and width select
    logic pulseClr;  // bit 11 written as 0
    logic clrVin;    // bit 7 written as 0
    logic clrExit;   // bit 8 written as 0
    logic clrFail;   // bit 9 written as 0
  } hotStrobe_t;
endpackage

// File: rtl/hot_alert_ctrl.sv
module hot_alert_ctrl
  import hot_alert_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] wrData,
  output logic              addrHit,
  output hotStrobe_t        stb
);
  logic wrHit;

  assign addrHit = (addr == STAT_ADDR);
  assign wrHit   = wrEn & addrHit;

  always_comb begin
    stb          = '0;
    stb.rdClr    = rdEn & addrHit;
    stb.cfgWr    = wrHit;
    stb.pulseClr = wrHit & ~wrData[B_CLR];
    stb.clrVin   = wrHit & ~wrData[B_VIN];
    stb.clrExit  = wrHit & ~wrData[B_EXIT];
    stb.clrFail  = wrHit & ~wrData[B_FAIL];
  end
endmodule

// File: rtl/hot_alert_timer.sv
module hot_alert_timer #(
  parameter int CLK_PER_US = 100,
  parameter int W_US0 = 100,
  parameter int W_US1 = 1000,
  parameter int W_US2 = 5000,
  parameter int W_US3 = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fire,
  input  logic       extEn,
  input  logic [1:0] widthSel,
  input  logic       pulseClr,
  output logic       pulseOn
);
  localparam int W_MAX01 = (W_US0 > W_US1) ? W_US0 : W_US1;
  localparam int W_MAX23 = (W_US2 > W_US3) ? W_US2 : W_US3;
  localparam int W_MAX   = (W_MAX01 > W_MAX23) ? W_MAX01 : W_MAX23;
  localparam int TMR_W   = $clog2(W_MAX + 1);
  localparam int PRE_W   = $clog2(CLK_PER_US + 1);

  logic [PRE_W-1:0] preCnt;
  logic [TMR_W-1:0] usLeft;
  logic [TMR_W-1:0] widthUs;
  logic             tick;

  always_comb begin
    case (widthSel)
      2'b00:   widthUs = TMR_W'(W_US0);
      2'b01:   widthUs = TMR_W'(W_US1);
      2'b10:   widthUs = TMR_W'(W_US2);
      default: widthUs = TMR_W'(W_US3);
    endcase
  end

  assign tick = (preCnt == PRE_W'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn <= 1'b0;
      usLeft  <= '0;
      preCnt  <= '0;
    end else if (fire) begin
      pulseOn <= 1'b1;
      usLeft  <= widthUs;
      preCnt  <= '0;
    end else if (pulseOn) begin
      if (extEn) begin
        if (pulseClr) pulseOn <= 1'b0;
      end else begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) begin
          usLeft <= usLeft - 1'b1;
          if (usLeft <= TMR_W'(1)) pulseOn <= 1'b0;
        end
      end
    end
  end

  a_r4_fire_starts: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> pulseOn);
  a_r6_ext_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && extEn && !pulseClr) |=> pulseOn);
  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    usLeft <= TMR_W'(W_MAX));
  a_r6_clear_ends: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && extEn && pulseClr && !fire) |=> !pulseOn);
endmodule

// File: rtl/hot_alert_dp.sv
module hot_alert_dp
  import hot_alert_pkg::*;
#(
  parameter int FAIL_LIMIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hotStrobe_t        stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [EVT_N-1:0]  evtIn,
  input  logic              tshutIn,
  input  logic              vinRegIn,
  input  logic              exitLoadIn,
  input  logic              loadTry,
  input  logic              loadOk,
  output logic [WORD_W-1:0] statWord,
  output logic              extEn,
  output logic [1:0]        widthSel,
  output logic              statVin,
  output logic              statExit,
  output logic              statFail
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);

  logic [EVT_N-1:0] evtLat;
  logic             tshutLat;
  logic [CNT_W-1:0] failCnt;
  logic             lastFail;
  logic             tryBad;

  assign tryBad   = loadTry & ~loadOk & ~statFail;
  assign lastFail = tryBad & (failCnt == CNT_W'(FAIL_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extEn    <= 1'b0;
      widthSel <= 2'b11;
      evtLat   <= '0;
      tshutLat <= 1'b0;
      statVin  <= 1'b0;
      statExit <= 1'b0;
      statFail <= 1'b0;
      failCnt  <= '0;
    end else begin
      if (stb.cfgWr) begin
        extEn    <= wrData[B_EXT];
        widthSel <= wrData[B_WHI:B_WLO];
      end
      evtLat   <= evtIn | (evtLat & {EVT_N{~stb.rdClr}});
      tshutLat <= tshutIn | (tshutLat & ~stb.rdClr);
      statVin  <= vinRegIn | (statVin & ~stb.clrVin);
      statExit <= exitLoadIn | (statExit & ~stb.clrExit);
      statFail <= lastFail | (statFail & ~stb.clrFail);
      if (loadTry && !statFail) begin
        if (loadOk || lastFail) failCnt <= '0;
        else                    failCnt <= failCnt + 1'b1;
      end
    end
  end

  assign statWord = {1'b1, extEn, widthSel, 1'b1, tshutLat, statFail,
                     statExit, statVin, evtLat};

  for (genvar i = 0; i < EVT_N; i++) begin : g_evtChk
    a_r2_evt_latch: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> statWord[i]);
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    failCnt < CNT_W'(FAIL_LIMIT));
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (statFail && !stb.clrFail) |=> statFail);
  a_r8_exit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (statExit && !stb.clrExit) |=> statExit);
  a_r10_tshut_latch: assert property (@(posedge clk) disable iff (!rstN)
    tshutIn |=> statWord[B_TSHUT]);
endmodule

// File: rtl/hot_alert_top.sv
module hot_alert_top
  import hot_alert_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h21,
  parameter int CLK_PER_US = 100,
  parameter int W_US0 = 100,
  parameter int W_US1 = 1000,
  parameter int W_US2 = 5000,
  parameter int W_US3 = 10000,
  parameter int FAIL_LIMIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [6:0]        evtIn,
  input  logic              tshutIn,
  input  logic              vinRegIn,
  input  logic              vinHoldEn,
  input  logic              exitLoadIn,
  input  logic              loadTry,
  input  logic              loadOk,
  output logic              alertN,
  output logic              latchedOff
);
  hotStrobe_t        stb;
  logic              addrHit;
  logic [WORD_W-1:0] statWord;
  logic              extEn;
  logic [1:0]        widthSel;
  logic              statVin;
  logic              statExit;
  logic              statFail;
  logic              pulseOn;
  logic              fire;

  hot_alert_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) i_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .addrHit(addrHit), .stb(stb)
  );

  hot_alert_dp #(.FAIL_LIMIT(FAIL_LIMIT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .evtIn(evtIn),
    .tshutIn(tshutIn), .vinRegIn(vinRegIn), .exitLoadIn(exitLoadIn),
    .loadTry(loadTry), .loadOk(loadOk), .statWord(statWord), .extEn(extEn),
    .widthSel(widthSel), .statVin(statVin), .statExit(statExit),
    .statFail(statFail)
  );

  assign fire = (|evtIn) | vinRegIn | exitLoadIn;

  hot_alert_timer #(
    .CLK_PER_US(CLK_PER_US), .W_US0(W_US0), .W_US1(W_US1),
    .W_US2(W_US2), .W_US3(W_US3)
  ) i_timer (
    .clk(clk), .rstN(rstN), .fire(fire), .extEn(extEn),
    .widthSel(widthSel), .pulseClr(stb.pulseClr), .pulseOn(pulseOn)
  );

  assign alertN     = ~(pulseOn | statExit | (statVin & vinHoldEn));
  assign latchedOff = statFail;
  assign rdData     = addrHit ? statWord : '0;

  a_r8_exit_low: assert property (@(posedge clk) disable iff (!rstN)
    statExit |-> !alertN);
  a_r7_vin_low: assert property (@(posedge clk) disable iff (!rstN)
    (statVin && vinHoldEn) |-> !alertN);
  a_r4_event_alert: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> !alertN);
endmodule

// File: tb/test_hot_alert_top.sv
`timescale 1ns/1ps
module test_hot_alert_top;
  localparam int P = 3;  // clocks per microsecond tick
  localparam logic [7:0] SA = 8'h21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = SA;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [6:0]  evtIn = '0;
  logic        tshutIn = 1'b0, vinRegIn = 1'b0, vinHoldEn = 1'b0;
  logic        exitLoadIn = 1'b0, loadTry = 1'b0, loadOk = 1'b0;
  logic        alertN, latchedOff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          kindQ[$];
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  hot_alert_top #(
    .ADDR_W(8), .STAT_ADDR(SA), .CLK_PER_US(P),
    .W_US0(4), .W_US1(6), .W_US2(8), .W_US3(10), .FAIL_LIMIT(7)
  ) i_hot_alert_top (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .tshutIn(tshutIn),
    .vinRegIn(vinRegIn), .vinHoldEn(vinHoldEn), .exitLoadIn(exitLoadIn),
    .loadTry(loadTry), .loadOk(loadOk), .alertN(alertN),
    .latchedOff(latchedOff)
  );

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (kindQ.size() > 0) begin
      int k;
      logic [15:0] e, act;
      string t;
      k = kindQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      case (k)
        0: act = rdData;
        1: act = {15'b0, alertN};
        default: act = {15'b0, latchedOff};
      endcase
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_(int kind, logic [15:0] val, string tag);
    kindQ.push_back(kind);
    expQ.push_back(val);
    tagQ.push_back(tag);
  endtask

  task automatic regWrite(logic [7:0] a, logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0; addr = SA;
  endtask

  task automatic regRead(logic [7:0] a, logic [15:0] e, string tag);
    addr = a; rdEn = 1'b1;
    expect_(0, e, tag);
    step();
    rdEn = 1'b0; addr = SA;
  endtask

  task automatic pulseCheck(int bitIdx, int cyc, string tag);
    evtIn[bitIdx] = 1'b1;
    step();
    evtIn = '0;
    expect_(1, 16'h0, tag);
    repeat (cyc - 1) step();
    expect_(1, 16'h0, tag);
    step();
    expect_(1, 16'h1, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    regRead(SA, 16'hB800, "R1");
    expect_(1, 16'h1, "R1");
    expect_(2, 16'h0, "R1");
    step();

    // R2 latch and clear-on-read
    evtIn = 7'b0000101;
    step();
    evtIn = '0;
    regRead(SA, 16'hB805, "R2");
    regRead(SA, 16'hB800, "R2");
    repeat (40) step();

    // R4 width codes 00 and 10
    regWrite(SA, 16'h0800);
    regRead(SA, 16'h8800, "R4");
    pulseCheck(3, 4 * P, "R4");
    regWrite(SA, 16'h2800);
    pulseCheck(6, 8 * P, "R4");
    regWrite(SA, 16'h0800);
    regRead(SA, 16'h8848, "R2");

    // R5 retrigger restarts the width
    evtIn[0] = 1'b1;
    step();
    evtIn = '0;
    repeat (4) step();
    pulseCheck(0, 4 * P, "R5");

    // R3 read-clear collides with an event
    regRead(SA, 16'h8801, "R3");
    addr = SA; rdEn = 1'b1; evtIn[1] = 1'b1;
    step();
    rdEn = 1'b0; evtIn = '0;
    regRead(SA, 16'h8802, "R3");
    repeat (20) step();

    // R6 extended pulse
    regWrite(SA, 16'h4800);
    evtIn[2] = 1'b1;
    step();
    evtIn = '0;
    repeat (50) step();
    expect_(1, 16'h0, "R6");
    regRead(SA, 16'hC804, "R6");
    regWrite(SA, 16'h4000);
    expect_(1, 16'h1, "R6");
    regRead(SA, 16'hC800, "R6");
    regWrite(SA, 16'h0800);

    // R7 regulation hold
    vinHoldEn = 1'b1;
    vinRegIn = 1'b1;
    step();
    vinRegIn = 1'b0;
    repeat (30) step();
    expect_(1, 16'h0, "R7");
    regWrite(SA, 16'h0880);
    expect_(1, 16'h0, "R7");
    regRead(SA, 16'h8880, "R7");
    regWrite(SA, 16'h0800);
    expect_(1, 16'h1, "R7");
    vinHoldEn = 1'b0;
    vinRegIn = 1'b1;
    step();
    vinRegIn = 1'b0;
    repeat (30) step();
    expect_(1, 16'h1, "R7");
    regWrite(SA, 16'h0800);

    // R8 exit-from-load hold
    exitLoadIn = 1'b1;
    step();
    exitLoadIn = 1'b0;
    repeat (30) step();
    expect_(1, 16'h0, "R8");
    regRead(SA, 16'h8900, "R8");
    regWrite(SA, 16'h0800);
    expect_(1, 16'h1, "R8");
    regRead(SA, 16'h8800, "R8");

    // R9 consecutive failures
    loadOk = 1'b0;
    for (int i = 0; i < 6; i++) begin
      loadTry = 1'b1; step(); loadTry = 1'b0; step();
    end
    expect_(2, 16'h0, "R9");
    loadTry = 1'b1; loadOk = 1'b1; step(); loadTry = 1'b0; loadOk = 1'b0;
    for (int i = 0; i < 6; i++) begin
      loadTry = 1'b1; step(); loadTry = 1'b0; step();
    end
    expect_(2, 16'h0, "R9");
    loadTry = 1'b1; step(); loadTry = 1'b0;
    expect_(2, 16'h1, "R9");
    regRead(SA, 16'h8A00, "R9");
    regWrite(SA, 16'h0800);
    expect_(2, 16'h0, "R9");

    // R10 thermal status without a pulse
    tshutIn = 1'b1;
    step();
    tshutIn = 1'b0;
    expect_(1, 16'h1, "R10");
    regRead(SA, 16'h8C00, "R10");
    regRead(SA, 16'h8800, "R10");

    // R11 foreign address
    regWrite(8'h22, 16'h7000);
    regRead(SA, 16'h8800, "R11");
    regRead(8'h22, 16'h0000, "R11");

    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule